// File: doc/BRIEF.md
# Quadratic Permutation Interleaver Address Generator

This block produces the permuted memory addresses that a turbo decoder needs to read its extrinsic data in interleaved order. A one-cycle start pulse captures the block length N and the two permutation coefficients f1 and f2. From the next cycle on, the block emits one address per clock for N cycles, along with the sequence index, a valid flag and a last flag. The address for index i is (f1*i + f2*i^2) mod N.

No multiplier, divider or stored address table is used. An increment register follows its own first-order recursion, and each new address is the previous address plus that increment. Every sum is brought back below N by one compare-and-subtract step. All coefficient inputs must be below N.

For a decoder with NUM_PE parallel processing elements, the address is also split into a bank number and a word address within that bank. The bank holds N/NUM_PE words. The split is done by comparing the address against multiples of the bank size.

Top module: `qpp_addr_gen`

## Requirements
- R1: After reset, valid_o and last_o are 0.
- R2: In the cycle after start_i is high, valid_o is 1, idx_o is 0 and addr_o is 0. The values of n_i, f1_i and f2_i present with start_i are the ones used for the whole block.
- R3: While valid_o is 1, addr_o equals (f1*idx_o + f2*idx_o^2) mod N.
- R4: idx_o rises by one per cycle, and valid_o stays high for exactly N consecutive cycles after a start.
- R5: last_o is 1 only in the cycle where idx_o equals N-1. In the cycle after that, valid_o is 0.
- R6: addr_o is always below N. For legal coefficient sets, the N addresses of a block form a permutation of 0..N-1.
- R7: bank_o equals addr_o / (N/NUM_PE) and word_o equals addr_o mod (N/NUM_PE). N must be a multiple of NUM_PE.
- R8: A start_i pulse while a block is running restarts the sequence at index 0 with the newly presented parameters.
- R9: Changes on n_i, f1_i and f2_i while start_i is low have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a new block and captures the parameters |
| n_i | input | N_W | Block length N |
| f1_i | input | N_W | Linear coefficient, must be below N |
| f2_i | input | N_W | Quadratic coefficient, must be below N |
| valid_o | output | 1 | An address is present on the outputs |
| last_o | output | 1 | Final address of the block |
| idx_o | output | N_W | Sequence index i |
| addr_o | output | N_W | Permuted address P(i) |
| bank_o | output | BANK_W | Bank number for parallel decoding |
| word_o | output | N_W | Word address within the bank |

## Verification
A wrong increment or step register does not stay hidden. From the next address on, the error accumulates with every cycle: all later addresses are wrong, and duplicates show up in the permutation scan. The bench therefore compares every emitted address against a closed-form multiply-and-mod value in the same cycle. A slip in the index counter or the last-flag compare shows up at the very end of the block, as a valid run that is one cycle too long or too short. A bad bank-size threshold shows up as soon as the address crosses the first bank boundary.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  localparam int unsigned N_W_DEF    = 13;
  localparam int unsigned NUM_PE_DEF = 4;
endpackage

// File: rtl/qpp_mod_add.sv
// (a + b) mod n for a, b < n: single compare-and-subtract
module qpp_mod_add #(
  parameter int unsigned N_W = 13
) (
  input  logic [N_W-1:0] a_i,
  input  logic [N_W-1:0] b_i,
  input  logic [N_W-1:0] n_i,
  output logic [N_W-1:0] sum_o
);
  logic [N_W:0] raw;
  logic [N_W:0] red;

  always_comb begin
    raw   = {1'b0, a_i} + {1'b0, b_i};
    red   = raw - {1'b0, n_i};
    sum_o = (raw >= {1'b0, n_i}) ? red[N_W-1:0] : raw[N_W-1:0];
  end
endmodule

// File: rtl/qpp_bank_split.sv
module qpp_bank_split #(
  parameter int unsigned N_W    = 13,
  parameter int unsigned NUM_PE = 4,
  localparam int unsigned PE_LOG = $clog2(NUM_PE),
  localparam int unsigned BANK_W = (PE_LOG > 0) ? PE_LOG : 1
) (
  input  logic [N_W-1:0]    addr_i,
  input  logic [N_W-1:0]    n_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [N_W-1:0]    word_o
);
  logic [N_W-1:0] seg;
  logic [N_W-1:0] thr [NUM_PE];

  assign seg    = n_i >> PE_LOG;
  assign thr[0] = '0;

  // bank boundaries k*seg built by a chain of adders
  for (genvar k = 1; k < NUM_PE; k++) begin : g_thr
    assign thr[k] = thr[k-1] + seg;
  end

  always_comb begin
    bank_o = '0;
    word_o = addr_i;
    for (int k = 1; k < NUM_PE; k++) begin
      if (addr_i >= thr[k]) begin
        bank_o = BANK_W'(k);
        word_o = addr_i - thr[k];
      end
    end
  end
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen #(
  parameter int unsigned N_W    = qpp_pkg::N_W_DEF,
  parameter int unsigned NUM_PE = qpp_pkg::NUM_PE_DEF,
  localparam int unsigned PE_LOG = $clog2(NUM_PE),
  localparam int unsigned BANK_W = (PE_LOG > 0) ? PE_LOG : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N_W-1:0]    n_i,
  input  logic [N_W-1:0]    f1_i,
  input  logic [N_W-1:0]    f2_i,
  output logic              valid_o,
  output logic              last_o,
  output logic [N_W-1:0]    idx_o,
  output logic [N_W-1:0]    addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [N_W-1:0]    word_o
);
  logic           valid_q;
  logic [N_W-1:0] n_q, idx_q, addr_q, g_q, d_q;
  logic [N_W-1:0] g0, d0, addr_nxt, g_nxt;
  logic           at_end;

  // g(0) = f1 + f2, step d = 2*f2, both reduced once at start
  qpp_mod_add #(.N_W(N_W)) i_g0 (.a_i(f1_i), .b_i(f2_i), .n_i(n_i), .sum_o(g0));
  qpp_mod_add #(.N_W(N_W)) i_d0 (.a_i(f2_i), .b_i(f2_i), .n_i(n_i), .sum_o(d0));
  // running recursion
  qpp_mod_add #(.N_W(N_W)) i_an (.a_i(addr_q), .b_i(g_q), .n_i(n_q), .sum_o(addr_nxt));
  qpp_mod_add #(.N_W(N_W)) i_gn (.a_i(g_q), .b_i(d_q), .n_i(n_q), .sum_o(g_nxt));

  assign at_end = (idx_q == n_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      n_q     <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      g_q     <= '0;
      d_q     <= '0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      n_q     <= n_i;
      idx_q   <= '0;
      addr_q  <= '0;
      g_q     <= g0;
      d_q     <= d0;
    end else if (valid_q) begin
      if (at_end) begin
        valid_q <= 1'b0;
      end else begin
        idx_q  <= idx_q + 1'b1;
        addr_q <= addr_nxt;
        g_q    <= g_nxt;
      end
    end
  end

  qpp_bank_split #(.N_W(N_W), .NUM_PE(NUM_PE)) i_split (
    .addr_i(addr_q), .n_i(n_q), .bank_o(bank_o), .word_o(word_o)
  );

  assign valid_o = valid_q;
  assign last_o  = valid_q & at_end;
  assign idx_o   = idx_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/qpp_addr_gen_chk.sv
module qpp_addr_gen_chk #(
  parameter int unsigned N_W    = 13,
  parameter int unsigned NUM_PE = 4,
  localparam int unsigned PE_LOG = $clog2(NUM_PE),
  localparam int unsigned BANK_W = (PE_LOG > 0) ? PE_LOG : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              valid_o,
  input logic              last_o,
  input logic [N_W-1:0]    idx_o,
  input logic [N_W-1:0]    addr_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [N_W-1:0]    word_o,
  input logic [N_W-1:0]    n_q
);
  // R2
  start_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && idx_o == '0 && addr_o == '0));

  // R4
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !start_i) |=> (valid_o && idx_o == $past(idx_o) + 1'b1));

  // R5
  last_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  // R5
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  // R6
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (addr_o < n_q));

  // R7
  word_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (word_o < (n_q >> PE_LOG) && 32'(bank_o) < NUM_PE));

  // R9
  hold_n_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> $stable(n_q));
endmodule

bind qpp_addr_gen qpp_addr_gen_chk #(.N_W(N_W), .NUM_PE(NUM_PE)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .valid_o(valid_o),
  .last_o(last_o), .idx_o(idx_o), .addr_o(addr_o), .bank_o(bank_o),
  .word_o(word_o), .n_q(n_q)
);

// File: tb/test_qpp_addr_gen.sv
module test_qpp_addr_gen;
  localparam int unsigned N_W    = 13;
  localparam int unsigned NUM_PE = 4;
  localparam int unsigned BANK_W = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N_W-1:0] n_in = '0, f1_in = '0, f2_in = '0;
  logic valid, last;
  logic [N_W-1:0] idx, addr, word;
  logic [BANK_W-1:0] bank;
  int checks = 0, errors = 0;
  bit done = 0;
  bit seen [8192];

  always #2 clk = ~clk;

  qpp_addr_gen #(.N_W(N_W), .NUM_PE(NUM_PE)) i_qpp_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .n_i(n_in), .f1_i(f1_in),
    .f2_i(f2_in), .valid_o(valid), .last_o(last), .idx_o(idx), .addr_o(addr),
    .bank_o(bank), .word_o(word)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ref_p(longint n, longint f1, longint f2, longint i);
    return (f1 * i + f2 * i * i) % n;
  endfunction

  task automatic pulse_start(input int n, input int f1, input int f2);
    @(negedge clk);
    n_in = N_W'(n); f1_in = N_W'(f1); f2_in = N_W'(f2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // runs `cnt` addresses (cnt == n runs the full block); scrambles inputs mid-block
  task automatic walk(input int n, input int f1, input int f2, input int cnt);
    longint seg = n / NUM_PE;
    bit perm_ok = 1;
    for (int k = 0; k < n; k++) seen[k] = 0;
    chk(valid && idx == 0 && addr == 0, "R2", longint'(addr), 0);
    for (int i = 0; i < cnt; i++) begin
      longint e = ref_p(n, f1, f2, i);
      if (i == 5) begin
        n_in = N_W'(n + 7); f1_in = N_W'(f2); f2_in = N_W'(f1 + 1);  // R9 scramble
      end
      chk(valid && longint'(idx) == i, "R4", longint'(idx), i);
      chk(longint'(addr) == e, (i > 5) ? "R3/R9" : "R3", longint'(addr), e);
      chk(longint'(bank) == e / seg && longint'(word) == e % seg, "R7",
          longint'(bank) * 100000 + longint'(word), (e / seg) * 100000 + e % seg);
      chk(last == (i == n - 1), "R5", longint'(last), longint'(i == n - 1));
      if (addr < N_W'(n)) begin
        if (seen[addr]) perm_ok = 0;
        seen[addr] = 1;
      end else perm_ok = 0;
      if (i != cnt - 1) @(negedge clk);
    end
    if (cnt == n) begin
      chk(perm_ok, "R6", longint'(perm_ok), 1);
      @(negedge clk);
      chk(!valid && !last, "R5", longint'(valid), 0);
    end
  endtask

  initial begin
    #1;
    chk(!valid && !last, "R1", longint'(valid), 0);
    #10 rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !last, "R1", longint'(valid), 0);

    pulse_start(40, 3, 10);    walk(40, 3, 10, 40);
    pulse_start(48, 7, 12);    walk(48, 7, 12, 48);
    pulse_start(56, 19, 42);   walk(56, 19, 42, 56);
    pulse_start(64, 7, 16);    walk(64, 7, 16, 64);
    pulse_start(72, 7, 18);    walk(72, 7, 18, 72);
    pulse_start(80, 11, 20);   walk(80, 11, 20, 80);
    // R8: restart mid-block with a different set
    pulse_start(104, 7, 26);   walk(104, 7, 26, 20);
    pulse_start(40, 3, 10);    walk(40, 3, 10, 40);
    pulse_start(6144, 263, 480); walk(6144, 263, 480, 6144);
    chk(!valid, "R4", longint'(valid), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule